// File: doc/BRIEF.md
# Hot-Plug and Receiver-Sense Deglitch Filter

This block turns two asynchronous level inputs, a hot-plug detect line and a receiver-sense line, into clean filtered levels. Each channel first passes through a synchroniser. A short glitch-reject stage then discards brief pulses. After that, a coarse stability stage holds back any change until the new level has lasted a programmable number of time units. One unit is `2**UNIT_LOG2` clocks, which is 1024 at the default setting. The filtered levels appear on a two-bit status output.

Every change of a filtered level also produces a one-clock event pulse: rise or fall, for each of the two channels. An interrupt block downstream latches and masks these pulses. The four width settings are static configuration inputs, and each channel has its own pair.

Top module: `plug_sense_filter`

## Requirements
- R1: Each raw input is synchronised through `SYNC_STAGES` (default 2) flops. With both widths of a channel at 0, a raw level change appears on that channel's status bit on the 4th rising clock edge after the change.
- R2: A raw pulse of N clocks or fewer, where N is the channel's 4-bit glitch width, changes neither the status bit nor any event output. A pulse of N+1 clocks passes the glitch stage.
- R3: A level change that lasts M×U clocks or fewer is rejected, where M is the 12-bit window width and U = 2**UNIT_LOG2. A change held for longer reaches status on edge N + M×U + 4 after the raw change.
- R4: Any return of a stage's input to the stage's current output restarts that stage's count from zero, so bounces inside a window never accumulate.
- R5: The hot-plug channel and the sense channel use only their own glitch and window settings, and each filters independently of the other.
- R6: While `rst_n` is low at a clock edge, the status bits and all four event outputs are 0 from the next cycle on, and all counters clear.
- R7: `status_o` bit 0 carries the filtered hot-plug level and bit 1 carries the filtered sense level.
- R8: The rise output of a channel is high for exactly one clock, in the cycle in which that channel's status bit has just gone from 0 to 1. The fall output behaves the same way for a change from 1 to 0. Neither output pulses at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plug_raw_i | input | 1 | Asynchronous hot-plug detect level |
| sense_raw_i | input | 1 | Asynchronous receiver-sense level |
| plug_glitch_i | input | GLITCH_W | Hot-plug glitch width N, static |
| plug_window_i | input | WINDOW_W | Hot-plug stability width M in units, static |
| sense_glitch_i | input | GLITCH_W | Sense glitch width N, static |
| sense_window_i | input | WINDOW_W | Sense stability width M in units, static |
| status_o | output | 2 | Filtered levels: bit 1 sense, bit 0 hot-plug |
| plug_rise_o | output | 1 | One-clock pulse on filtered hot-plug rise |
| plug_fall_o | output | 1 | One-clock pulse on filtered hot-plug fall |
| sense_rise_o | output | 1 | One-clock pulse on filtered sense rise |
| sense_fall_o | output | 1 | One-clock pulse on filtered sense fall |

## Verification
The bench keeps the full 4-bit glitch width and 12-bit window width but builds the block with `UNIT_LOG2` = 2, so one window unit is 4 clocks instead of 1024. With that setting, the boundaries between rejected and passed pulses in the stability stage (8 versus 9 clocks at M = 2) fall within a few dozen cycles. The exact end-to-end latency N + M×U + 4 can then be checked edge by edge. The same unit size lets the bounce test show that two sub-window bursts, which would exceed the window if their counts were added together, are still rejected.

// File: rtl/psf_pkg.sv
// Package: shared defaults and channel indices for the hot-plug/sense filter.
// Assumes exactly two channels; index order fixes the status bit positions.
package psf_pkg;
    localparam int DEF_GLITCH_W = 4;
    localparam int DEF_WINDOW_W = 12;
    localparam int DEF_UNIT_LOG2 = 10;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int NUM_CH = 2;

    typedef enum int {
        CH_PLUG  = 0,
        CH_SENSE = 1
    } psf_chan_e;
endpackage

// File: rtl/psf_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module psf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/psf_qualify.sv
// Module: level qualifier. The output follows the input only after the
// input has differed from it on (limit << SHIFT) + 1 consecutive edges.
// Assumes the input is already synchronous; a limit of 0 gives one
// register of delay. The count restarts whenever the input matches the output.
module psf_qualify #(
    parameter int LIM_W = 4,
    parameter int SHIFT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             lvl_o
);
    localparam int CNT_W = LIM_W + SHIFT;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thresh;
    logic             held;

    // Scale the limit by the unit size.
    always_comb begin
        thresh = CNT_W'(limit_i) << SHIFT;
    end

    // Count the edges on which input and output disagree; commit at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (lvl_i == held) begin
            cnt <= '0;
        end else if (cnt >= thresh) begin
            held <= lvl_i;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign lvl_o = held;
endmodule

// File: rtl/psf_edge.sv
// Module: edge detector producing one-clock rise and fall pulses.
// Assumes the input is a registered level; the pulses are decoded from registers.
module psf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl_i;
    end

    // Decode the transitions.
    always_comb begin
        rise_o = lvl_i & ~prev;
        fall_o = ~lvl_i & prev;
    end
endmodule

// File: rtl/psf_channel.sv
// Module: one filter channel: synchroniser, glitch stage, stability stage
// and edge pulses. Assumes the width settings are static while in use.
module psf_channel #(
    parameter int GLITCH_W    = 4,
    parameter int WINDOW_W    = 12,
    parameter int UNIT_LOG2   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw_i,
    input  logic [GLITCH_W-1:0] glitch_i,
    input  logic [WINDOW_W-1:0] window_i,
    output logic                level_o,
    output logic                rise_o,
    output logic                fall_o
);
    logic synced;
    logic deglitched;

    psf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_i),
        .sync_o (synced)
    );

    psf_qualify #(.LIM_W(GLITCH_W), .SHIFT(0)) u_glitch (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (synced),
        .limit_i(glitch_i),
        .lvl_o  (deglitched)
    );

    psf_qualify #(.LIM_W(WINDOW_W), .SHIFT(UNIT_LOG2)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (deglitched),
        .limit_i(window_i),
        .lvl_o  (level_o)
    );

    psf_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (level_o),
        .rise_o(rise_o),
        .fall_o(fall_o)
    );
endmodule

// File: rtl/plug_sense_filter.sv
// Module: top of the hot-plug and receiver-sense deglitch filter.
// Two independent channels are built by a generate loop. Status bit
// positions follow the channel index in psf_pkg.
// Assumes the configuration inputs are static.
module plug_sense_filter
    import psf_pkg::*;
#(
    parameter int GLITCH_W    = DEF_GLITCH_W,
    parameter int WINDOW_W    = DEF_WINDOW_W,
    parameter int UNIT_LOG2   = DEF_UNIT_LOG2,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                plug_raw_i,
    input  logic                sense_raw_i,
    input  logic [GLITCH_W-1:0] plug_glitch_i,
    input  logic [WINDOW_W-1:0] plug_window_i,
    input  logic [GLITCH_W-1:0] sense_glitch_i,
    input  logic [WINDOW_W-1:0] sense_window_i,
    output logic [1:0]          status_o,
    output logic                plug_rise_o,
    output logic                plug_fall_o,
    output logic                sense_rise_o,
    output logic                sense_fall_o
);
    logic [NUM_CH-1:0]   raw_v;
    logic [GLITCH_W-1:0] glitch_v [NUM_CH];
    logic [WINDOW_W-1:0] window_v [NUM_CH];
    logic [NUM_CH-1:0]   level_v;
    logic [NUM_CH-1:0]   rise_v;
    logic [NUM_CH-1:0]   fall_v;

    // Gather the per-channel inputs into indexed form.
    always_comb begin
        raw_v[CH_PLUG]     = plug_raw_i;
        raw_v[CH_SENSE]    = sense_raw_i;
        glitch_v[CH_PLUG]  = plug_glitch_i;
        glitch_v[CH_SENSE] = sense_glitch_i;
        window_v[CH_PLUG]  = plug_window_i;
        window_v[CH_SENSE] = sense_window_i;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        psf_channel #(
            .GLITCH_W   (GLITCH_W),
            .WINDOW_W   (WINDOW_W),
            .UNIT_LOG2  (UNIT_LOG2),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_v[c]),
            .glitch_i(glitch_v[c]),
            .window_i(window_v[c]),
            .level_o (level_v[c]),
            .rise_o  (rise_v[c]),
            .fall_o  (fall_v[c])
        );
    end

    // Spread the channel results onto the named outputs.
    always_comb begin
        status_o     = level_v;
        plug_rise_o  = rise_v[CH_PLUG];
        plug_fall_o  = fall_v[CH_PLUG];
        sense_rise_o = rise_v[CH_SENSE];
        sense_fall_o = fall_v[CH_SENSE];
    end
endmodule

// File: rtl/psf_checker.sv
// Module: property checker for plug_sense_filter, attached by bind.
// Assumes the synchronous active-low reset of the top module.
module psf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] status_o,
    input logic       plug_rise_o,
    input logic       plug_fall_o,
    input logic       sense_rise_o,
    input logic       sense_fall_o
);
    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o == 2'b00) && !plug_rise_o && !plug_fall_o
                   && !sense_rise_o && !sense_fall_o);

    // R8
    plug_rise_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plug_rise_o |=> !plug_rise_o);

    // R8
    sense_fall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_fall_o |=> !sense_fall_o);

    // R8
    plug_rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> plug_rise_o);

    // R8
    plug_fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> plug_fall_o);

    // R8
    sense_rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> sense_rise_o);

    // R8
    sense_fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[1]) |-> sense_fall_o);

    // R8
    plug_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status_o[0]) |-> !plug_rise_o && !plug_fall_o);
endmodule

bind plug_sense_filter psf_checker u_psf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_o    (status_o),
    .plug_rise_o (plug_rise_o),
    .plug_fall_o (plug_fall_o),
    .sense_rise_o(sense_rise_o),
    .sense_fall_o(sense_fall_o)
);

// File: tb/sim_plug_sense_filter.sv
`timescale 1ns/1ps
// Bench: directed scenarios for plug_sense_filter, one task per scenario.
module sim_plug_sense_filter;
    localparam int GW = 4;
    localparam int WW = 12;
    localparam int UL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          plug_raw = 1'b0;
    logic          sense_raw = 1'b0;
    logic [GW-1:0] plug_glitch = '0;
    logic [WW-1:0] plug_window = '0;
    logic [GW-1:0] sense_glitch = '0;
    logic [WW-1:0] sense_window = '0;
    logic [1:0]    status;
    logic          plug_rise, plug_fall, sense_rise, sense_fall;

    int n_chk = 0;
    int n_err = 0;
    int ev_cnt = 0;

    always #2 clk = ~clk;

    plug_sense_filter #(.GLITCH_W(GW), .WINDOW_W(WW), .UNIT_LOG2(UL)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .plug_raw_i    (plug_raw),
        .sense_raw_i   (sense_raw),
        .plug_glitch_i (plug_glitch),
        .plug_window_i (plug_window),
        .sense_glitch_i(sense_glitch),
        .sense_window_i(sense_window),
        .status_o      (status),
        .plug_rise_o   (plug_rise),
        .plug_fall_o   (plug_fall),
        .sense_rise_o  (sense_rise),
        .sense_fall_o  (sense_fall)
    );

    // Count the cycles in which any event output is high.
    always @(negedge clk) begin
        if (plug_rise || plug_fall || sense_rise || sense_fall) ev_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        plug_raw = 1'b0;
        sense_raw = 1'b0;
        ticks(30);
        plug_glitch = '0;
        plug_window = '0;
        sense_glitch = '0;
        sense_window = '0;
        ticks(2);
    endtask

    task automatic t_reset();
        ticks(3);
        chk("R6 status in reset", int'(status), 0);
        chk("R6 events in reset", int'({plug_rise, plug_fall, sense_rise, sense_fall}), 0);
        rst_n = 1'b1;
        ticks(2);
    endtask

    task automatic t_pass();
        plug_raw = 1'b1;
        ticks(3);
        chk("R1 status before edge 4", int'(status), 0);
        ticks(1);
        chk("R1 status at edge 4", int'(status), 1);
        chk("R8 plug rise pulse", int'(plug_rise), 1);
        chk("R8 no plug fall on rise", int'(plug_fall), 0);
        ticks(1);
        chk("R8 plug rise one clock", int'(plug_rise), 0);
        plug_raw = 1'b0;
        ticks(4);
        chk("R1 fall at edge 4", int'(status), 0);
        chk("R8 plug fall pulse", int'(plug_fall), 1);
        ticks(1);
        chk("R8 plug fall one clock", int'(plug_fall), 0);
        sense_raw = 1'b1;
        ticks(4);
        chk("R7 sense on status bit 1", int'(status), 2);
        chk("R8 sense rise pulse", int'(sense_rise), 1);
        settle();
    endtask

    task automatic t_glitch();
        int base;
        plug_glitch = 4'd3;
        ticks(2);
        base = ev_cnt;
        plug_raw = 1'b1;
        ticks(3);
        plug_raw = 1'b0;
        ticks(15);
        chk("R2 3-clock pulse rejected status", int'(status), 0);
        chk("R2 3-clock pulse no events", ev_cnt - base, 0);
        plug_raw = 1'b1;
        ticks(4);
        plug_raw = 1'b0;
        ticks(2);
        chk("R2 4-clock pulse not yet", int'(status), 0);
        ticks(1);
        chk("R2 4-clock pulse passes at N+4", int'(status), 1);
        chk("R2 rise with glitch width", int'(plug_rise), 1);
        ticks(3);
        chk("R2 level held", int'(status), 1);
        ticks(1);
        chk("R2 fall after glitch stage", int'(status), 0);
        chk("R2 fall pulse", int'(plug_fall), 1);
        settle();
    endtask

    task automatic t_window();
        int base;
        plug_window = 12'd2;
        ticks(2);
        base = ev_cnt;
        plug_raw = 1'b1;
        ticks(8);
        plug_raw = 1'b0;
        ticks(20);
        chk("R3 8-clock change rejected", int'(status), 0);
        chk("R3 8-clock change no events", ev_cnt - base, 0);
        plug_raw = 1'b1;
        ticks(9);
        plug_raw = 1'b0;
        ticks(2);
        chk("R3 9-clock change before edge 12", int'(status), 0);
        ticks(1);
        chk("R3 9-clock change at edge 12", int'(status), 1);
        chk("R3 rise after window", int'(plug_rise), 1);
        ticks(8);
        chk("R3 held until edge 21", int'(status), 1);
        ticks(1);
        chk("R3 fall at edge 21", int'(status), 0);
        settle();
    endtask

    task automatic t_bounce();
        int base;
        plug_window = 12'd2;
        ticks(2);
        base = ev_cnt;
        plug_raw = 1'b1;
        ticks(6);
        plug_raw = 1'b0;
        ticks(1);
        plug_raw = 1'b1;
        ticks(6);
        plug_raw = 1'b0;
        ticks(25);
        chk("R4 window restarts on bounce", int'(status), 0);
        chk("R4 window bounce no events", ev_cnt - base, 0);
        plug_window = '0;
        plug_glitch = 4'd3;
        ticks(2);
        plug_raw = 1'b1;
        ticks(3);
        plug_raw = 1'b0;
        ticks(1);
        plug_raw = 1'b1;
        ticks(3);
        plug_raw = 1'b0;
        ticks(15);
        chk("R4 glitch restarts on bounce", int'(status), 0);
        chk("R4 glitch bounce no events", ev_cnt - base, 0);
        settle();
    endtask

    task automatic t_indep();
        sense_glitch = 4'd5;
        sense_window = 12'd1;
        ticks(2);
        plug_raw = 1'b1;
        sense_raw = 1'b1;
        ticks(4);
        chk("R5 plug unaffected by sense settings", int'(status), 1);
        ticks(8);
        chk("R5 sense still filtering", int'(status), 1);
        ticks(1);
        chk("R5 sense passes at edge 13", int'(status), 3);
        chk("R5 sense rise pulse", int'(sense_rise), 1);
        chk("R5 no plug event then", int'(plug_rise), 0);
        settle();
        chk("R5 both back low", int'(status), 0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_glitch();
        t_window();
        t_bounce();
        t_indep();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule